// File: doc/BRIEF.md
# Interrupt Vector Dispatch Bridge

This block sits between sixteen legacy peripheral interrupt lines and a processor that takes interrupts as numbered vectors. Each line is synchronized and watched for edges. A rising edge on a line that has a vector assigned raises that vector toward the processor. A falling edge lowers whatever is pending. Only five of the lines carry a vector. The others are left alone.

Delivery uses a single slot. When the slot is free, an accepted raise marks it busy and latches a 64-bit descriptor word. The descriptor holds a fixed five-bit tag of all ones just above the six-bit vector number. Two further descriptor words are cleared. The block then asserts a level hard-interrupt request and gives a one-cycle wake pulse. While the slot is busy, every new raise is discarded. Software frees the slot with an acknowledge pulse, or a mapped line falls. Software can read the status word and the three descriptor words through a small combinational read port. The trap index the processor should take is presented as well. That index ranks above all level interrupts.

Top module: `ivec_dispatch_bridge`

## Requirements
- R1: After reset, and while reset is held, the following are all zero: `hard_irq`, `wake`, `trap_index` and every readable word.
- R2: The line-to-vector map is: line 1 to 0x29, line 4 to 0x2B, line 6 to 0x27, line 7 to 0x22, line 12 to 0x2A. An accepted raise latches descriptor word 0 as bits 10:6 = 0x1F and bits 5:0 = vector, with upper bits zero (line 1 gives 0x7E9).
- R3: A rising edge on any line outside the map leaves the block idle: no request, no wake, status reads zero.
- R4: An accepted raise sets bit 5 of the status word (`rd_sel`=0 reads 0x20), asserts `hard_irq`, and leaves words 1 and 2 (`rd_sel`=2, 3) at zero. `rd_sel`=1 reads word 0.
- R5: `wake` is high for exactly one cycle, in the first cycle that `hard_irq` is high.
- R6: A raise that arrives while the slot is busy is dropped. Descriptor word 0 is unchanged, no wake pulse occurs, and no raise is held back for later.
- R7: An `irq_ack` pulse while busy clears the busy bit and `hard_irq` on the next edge. An `irq_ack` pulse while idle changes nothing.
- R8: A falling edge on a mapped line while busy lowers the request. A falling edge while idle changes nothing.
- R9: When several mapped lines rise in the same cycle, the lowest-numbered one is delivered. The rest are discarded and do not appear after the slot frees.
- R10: `trap_index` is 0x060 while `hard_irq` is high and zero otherwise.
- R11: A line change reaches `hard_irq` on the third rising clock edge after it is applied: two synchronizer stages plus the slot register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy_irq | input | 16 | Asynchronous legacy interrupt lines |
| irq_ack | input | 1 | Software lower/acknowledge pulse |
| rd_sel | input | 2 | Read select: 0 status, 1..3 descriptor words 0..2 |
| rd_data | output | 64 | Selected register value |
| hard_irq | output | 1 | Hard-interrupt request level |
| wake | output | 1 | One-cycle wake pulse on delivery |
| trap_index | output | 9 | Trap type to take while a vector is pending |

## Verification
The properties assume that `irq_ack` is a single-cycle pulse. They also assume that legacy lines change no more than once per clock, so each edge passes through the synchronizer cleanly. The stimulus drives every input on the falling clock edge. It holds each line level for at least three cycles before changing it, and it never issues an acknowledge in the same cycle that a raise lands. As a result, the priority between a simultaneous raise and lower is never relied on.

// File: rtl/ivd_pkg.sv
package ivd_pkg;

    localparam int NUM_LINES  = 16;
    localparam int NUM_VEC    = 48;
    localparam int VEC_W      = $clog2(NUM_VEC);
    localparam int DATA_W     = 64;
    localparam int TAG_W      = 5;
    localparam logic [TAG_W-1:0] DESC_TAG = 5'h1f;
    localparam int BUSY_BIT   = 5;
    localparam int TRAP_W     = 9;
    localparam logic [TRAP_W-1:0] TRAP_VECTORED = 9'h060;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_WORD0  = 2'd1,
        SEL_WORD1  = 2'd2,
        SEL_WORD2  = 2'd3
    } rd_sel_e;

    typedef struct packed {
        logic              busy;
        logic              wake;
        logic [DATA_W-1:0] word0;
        logic [DATA_W-1:0] word1;
        logic [DATA_W-1:0] word2;
    } slot_state_t;

    // Sparse legacy-line map; zero means the line carries no vector.
    function automatic logic [VEC_W-1:0] line_vector(input int unsigned idx);
        case (idx)
            1:       return 6'h29;
            4:       return 6'h2b;
            6:       return 6'h27;
            7:       return 6'h22;
            12:      return 6'h2a;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/ivd_line_sync.sv
module ivd_line_sync #(
    parameter int N      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines_async,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    // pipe_q[STAGES-1] is the synchronized level, pipe_q[STAGES] its last value
    logic [STAGES:0][N-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = pipe_q;
        pipe_d[0] = lines_async;
        for (int s = 1; s <= STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_edge
        assign rise[g] =  pipe_q[STAGES-1][g] & ~pipe_q[STAGES][g];
        assign fall[g] = ~pipe_q[STAGES-1][g] &  pipe_q[STAGES][g];
    end

endmodule

// File: rtl/ivd_line_select.sv
module ivd_line_select
    import ivd_pkg::*;
#(
    parameter int N = NUM_LINES
) (
    input  logic [N-1:0]     rise,
    input  logic [N-1:0]     fall,
    output logic             raise_valid,
    output logic [VEC_W-1:0] raise_vec,
    output logic             lower_any
);
    logic [N-1:0] mapped;

    for (genvar g = 0; g < N; g++) begin : g_map
        assign mapped[g] = (line_vector(g) != '0);
    end

    // Scan downward so the lowest-numbered mapped rise is the one kept.
    always_comb begin
        raise_valid = 1'b0;
        raise_vec   = '0;
        for (int i = N-1; i >= 0; i--) begin
            if (rise[i] && mapped[i]) begin
                raise_valid = 1'b1;
                raise_vec   = line_vector(i);
            end
        end
    end

    assign lower_any = |(fall & mapped);

endmodule

// File: rtl/ivd_slot.sv
module ivd_slot
    import ivd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raise_valid,
    input  logic [VEC_W-1:0]  raise_vec,
    input  logic              lower_req,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] word0,
    output logic              hard_irq,
    output logic              wake,
    output logic [TRAP_W-1:0] trap_index
);
    slot_state_t st_d, st_q;
    logic [DATA_W-1:0] desc_d;
    logic [DATA_W-1:0] status_w;

    always_comb begin
        desc_d = '0;
        desc_d[VEC_W-1:0]        = raise_vec;
        desc_d[VEC_W +: TAG_W]   = DESC_TAG;

        st_d      = st_q;
        st_d.wake = 1'b0;
        if (st_q.busy) begin
            // raises are dropped while occupied; only a lower frees the slot
            if (lower_req) st_d.busy = 1'b0;
        end else if (raise_valid) begin
            st_d.busy  = 1'b1;
            st_d.wake  = 1'b1;
            st_d.word0 = desc_d;
            st_d.word1 = '0;
            st_d.word2 = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status_w = '0;
        status_w[BUSY_BIT] = st_q.busy;
        case (rd_sel_e'(rd_sel))
            SEL_STATUS: rd_data = status_w;
            SEL_WORD0:  rd_data = st_q.word0;
            SEL_WORD1:  rd_data = st_q.word1;
            default:    rd_data = st_q.word2;
        endcase
    end

    assign word0      = st_q.word0;
    assign hard_irq   = st_q.busy;
    assign wake       = st_q.wake;
    assign trap_index = st_q.busy ? TRAP_VECTORED : '0;

endmodule

// File: rtl/ivec_dispatch_bridge.sv
module ivec_dispatch_bridge
    import ivd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       legacy_irq,
    input  logic              irq_ack,
    input  logic [1:0]        rd_sel,
    output logic [63:0]       rd_data,
    output logic              hard_irq,
    output logic              wake,
    output logic [8:0]        trap_index
);
    logic [NUM_LINES-1:0] rise_w, fall_w;
    logic                 raise_valid_w;
    logic [VEC_W-1:0]     raise_vec_w;
    logic                 lower_any_w;
    logic [DATA_W-1:0]    word0_w;

    ivd_line_sync #(.N(NUM_LINES), .STAGES(2)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .lines_async (legacy_irq),
        .rise        (rise_w),
        .fall        (fall_w)
    );

    ivd_line_select #(.N(NUM_LINES)) u_select (
        .rise        (rise_w),
        .fall        (fall_w),
        .raise_valid (raise_valid_w),
        .raise_vec   (raise_vec_w),
        .lower_any   (lower_any_w)
    );

    ivd_slot u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .raise_valid (raise_valid_w),
        .raise_vec   (raise_vec_w),
        .lower_req   (lower_any_w | irq_ack),
        .rd_sel      (rd_sel),
        .rd_data     (rd_data),
        .word0       (word0_w),
        .hard_irq    (hard_irq),
        .wake        (wake),
        .trap_index  (trap_index)
    );

endmodule

// File: rtl/ivec_dispatch_bridge_chk.sv
module ivec_dispatch_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        hard_irq,
    input logic        wake,
    input logic        irq_ack,
    input logic [8:0]  trap_index,
    input logic [63:0] word0
);
    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);                                            // R5
    AST_WAKE_ON_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hard_irq) |-> wake);                                  // R5
    AST_DESC_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        hard_irq |-> (word0[10:6] == 5'h1f));                       // R2
    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (hard_irq && $past(hard_irq)) |-> ($stable(word0) && !wake)); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (hard_irq && irq_ack) |=> !hard_irq);                       // R7
    AST_TRAP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        hard_irq |-> (trap_index == 9'h060));                       // R10
    AST_TRAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !hard_irq |-> (trap_index == 9'h000));                      // R10
endmodule

bind ivec_dispatch_bridge ivec_dispatch_bridge_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hard_irq   (hard_irq),
    .wake       (wake),
    .irq_ack    (irq_ack),
    .trap_index (trap_index),
    .word0      (word0_w)
);

// File: tb/ivec_dispatch_bridge_tb.sv
module ivec_dispatch_bridge_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] legacy_irq = '0;
    logic        irq_ack = 1'b0;
    logic [1:0]  rd_sel = 2'd0;
    logic [63:0] rd_data;
    logic        hard_irq;
    logic        wake;
    logic [8:0]  trap_index;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ivec_dispatch_bridge u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .legacy_irq (legacy_irq),
        .irq_ack    (irq_ack),
        .rd_sel     (rd_sel),
        .rd_data    (rd_data),
        .hard_irq   (hard_irq),
        .wake       (wake),
        .trap_index (trap_index)
    );

    // stimulus table: line index and the vector it should deliver (0 = none)
    localparam int NT = 10;
    localparam logic [3:0] T_LINE [NT] = '{4'd0, 4'd1, 4'd3, 4'd4, 4'd6,
                                           4'd7, 4'd9, 4'd12, 4'd13, 4'd15};
    localparam logic [5:0] T_VEC  [NT] = '{6'h00, 6'h29, 6'h00, 6'h2b, 6'h27,
                                           6'h22, 6'h00, 6'h2a, 6'h00, 6'h00};

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] s, output logic [63:0] v);
        rd_sel = s;
        #1;
        v = rd_data;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_ack();
        @(negedge clk) irq_ack = 1'b1;
        @(negedge clk) irq_ack = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [63:0] v;
        edges(3);
        // R1: held in reset
        check("R1 irq in reset", {63'b0, hard_irq}, 64'd0);
        @(negedge clk) rst_n = 1'b1;
        edges(1);
        check("R1 irq", {63'b0, hard_irq}, 64'd0);
        check("R1 wake", {63'b0, wake}, 64'd0);
        check("R1 trap", {55'b0, trap_index}, 64'd0);
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), v);
            check("R1 reg", v, 64'd0);
        end

        // table walk
        for (int k = 0; k < NT; k++) begin
            @(negedge clk) legacy_irq[T_LINE[k]] = 1'b1;
            edges(2);
            check("R11 not yet", {63'b0, hard_irq}, 64'd0);
            edges(1);
            if (T_VEC[k] != 0) begin
                check("R4 irq", {63'b0, hard_irq}, 64'd1);
                check("R5 wake", {63'b0, wake}, 64'd1);
                check("R10 trap", {55'b0, trap_index}, 64'h60);
                rd(2'd0, v); check("R4 status", v, 64'h20);
                rd(2'd1, v); check("R2 word0", v, 64'h7c0 | 64'(T_VEC[k]));
                rd(2'd2, v); check("R4 word1", v, 64'd0);
                rd(2'd3, v); check("R4 word2", v, 64'd0);
                edges(1);
                check("R5 wake drop", {63'b0, wake}, 64'd0);
                if (k % 2 == 0) begin
                    pulse_ack();
                    #1;
                    check("R7 ack clears", {63'b0, hard_irq}, 64'd0);
                    check("R10 trap idle", {55'b0, trap_index}, 64'd0);
                    @(negedge clk) legacy_irq[T_LINE[k]] = 1'b0;
                    edges(4);
                    check("R8 idle fall", {63'b0, hard_irq}, 64'd0);
                end else begin
                    @(negedge clk) legacy_irq[T_LINE[k]] = 1'b0;
                    edges(3);
                    check("R8 fall lowers", {63'b0, hard_irq}, 64'd0);
                    rd(2'd0, v); check("R8 status", v, 64'd0);
                end
            end else begin
                check("R3 unmapped irq", {63'b0, hard_irq}, 64'd0);
                check("R3 unmapped wake", {63'b0, wake}, 64'd0);
                rd(2'd0, v); check("R3 status", v, 64'd0);
                @(negedge clk) legacy_irq[T_LINE[k]] = 1'b0;
                edges(3);
            end
        end

        // R6: raise while busy is dropped
        @(negedge clk) legacy_irq[1] = 1'b1;
        edges(3);
        check("R6 first", {63'b0, hard_irq}, 64'd1);
        @(negedge clk) legacy_irq[4] = 1'b1;
        for (int c = 0; c < 4; c++) begin
            edges(1);
            check("R6 no wake", {63'b0, wake}, 64'd0);
        end
        rd(2'd1, v); check("R6 word0 kept", v, 64'h7e9);
        pulse_ack();
        edges(4);
        check("R6 not queued", {63'b0, hard_irq}, 64'd0);
        @(negedge clk) legacy_irq = '0;
        edges(4);

        // R7: ack while idle
        pulse_ack();
        #1;
        check("R7 idle ack", {63'b0, hard_irq}, 64'd0);
        rd(2'd1, v); check("R7 idle word0", v, 64'h7e9);

        // R9: simultaneous rises, lowest mapped wins
        @(negedge clk) legacy_irq = 16'h1011; // lines 0, 4, 12
        edges(3);
        check("R9 irq", {63'b0, hard_irq}, 64'd1);
        rd(2'd1, v); check("R9 lowest", v, 64'h7eb);
        pulse_ack();
        edges(5);
        check("R9 rest dropped", {63'b0, hard_irq}, 64'd0);
        @(negedge clk) legacy_irq = '0;
        edges(4);

        // R1: reset while busy
        @(negedge clk) legacy_irq[6] = 1'b1;
        edges(3);
        check("R1 pre busy", {63'b0, hard_irq}, 64'd1);
        @(negedge clk) rst_n = 1'b0;
        edges(1);
        check("R1 reset busy", {63'b0, hard_irq}, 64'd0);
        rd(2'd1, v); check("R1 reset word0", v, 64'd0);
        @(negedge clk) begin legacy_irq = '0; rst_n = 1'b1; end
        edges(4);
        check("R1 after", {63'b0, hard_irq}, 64'd0);

        finish_run();
    end

endmodule